// File: doc/BRIEF.md
# SPI Sequencer Register and Interrupt Front End

This block is the register side of an SPI sequencing engine. A host reaches it through a simple bus that completes every access in one cycle. The bus has a select, a write strobe, a byte offset, write data and combinational read data. Inside the block are three queues. A command queue holds 16-bit instruction words. A transmit queue holds the bytes to be shifted out. A receive queue collects the bytes shifted in. The engine pops the command and transmit queues and pushes the receive queue through its own side ports. The host fills and drains the queues by writing or reading fixed offsets, and reads how much room or how much data each queue currently has.

A core reset bit holds the engine in reset and keeps every queue flushed while it is set. It comes out of reset set, so software must clear it before starting. When the engine completes a marker instruction it reports an identifier. The block stores that identifier for the host to read and raises a completion condition. Four raw conditions feed the interrupt logic: command queue low, transmit queue low, receive queue high, and marker reached. Each condition sets a pending bit. Writing 1 to a pending bit clears it. The single interrupt line is high while any pending bit is also enabled.

Top module: `spi_seq_regfile`

## Requirements
- R1: A read of offset 0x00 returns the version word: bits 23:16 hold the major number, which is 1; bits 15:8 hold the minor number (0); bits 7:0 hold the patch (0x61); bits 31:24 read 0.
- R2: Offset 0x40 bit 0 is the core reset control. It is 1 after `rst_n`, it reads back as written, and `eng_rst` follows it from the cycle after the write.
- R3: While the core reset bit is 1, from the cycle after it becomes 1 onward, all three queues are empty, the marker identifier at 0xC0 reads 0, and queue pushes from the bus or the engine have no effect.
- R4: A write to 0xE0 appends bits 15:0 to the command queue. The engine sees the oldest word on `cmd_data` with `cmd_valid` high, and `cmd_pop` removes it. A read of 0xD0 returns the queue depth minus the stored word count.
- R5: A write to 0xE4 appends bits 7:0 to the transmit queue. The engine sees it in order on `tx_data`/`tx_valid` and removes it with `tx_pop`. A read of 0xD4 returns the free room.
- R6: `rx_push` appends `rx_data` to the receive queue. A read of 0xD8 returns its fill level. A read of 0xE8 returns the oldest byte and removes it. A read of 0xEC returns the oldest byte and leaves the queue unchanged.
- R7: A push into a full queue, from the bus or from the engine, is dropped: room stays 0, or level stays at the depth, and the stored contents are unchanged.
- R8: A read of 0xE8 or 0xEC on an empty receive queue returns 0 and leaves the level at 0.
- R9: Offset 0x88 returns the raw conditions. Bit 0 is set when the command level is at most 4. Bit 1 is set when the transmit level is at most 4. Bit 2 is set when the receive level is at least depth minus 4. Bit 3 is set in the cycle `sync_valid` is high.
- R10: Offset 0x84 returns the pending bits. A raw condition sets its bit on the next edge. Writing 1 to a bit clears it, unless its condition is still active, in which case setting wins. Writing 0 leaves the bit unchanged.
- R11: Offset 0x80 holds the 4-bit enable mask, which is 0 after `rst_n`. `irq` is high exactly when some pending bit is also enabled.
- R12: When `sync_valid` is high outside core reset, `sync_id` is stored, and a read of 0xC0 returns it from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| eng_rst | output | 1 | Engine reset hold |
| cmd_valid | output | 1 | Command queue not empty |
| cmd_data | output | 16 | Oldest command word |
| cmd_pop | input | 1 | Engine takes the command word |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Engine takes the transmit byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| sync_valid | input | 1 | Engine reached a marker |
| sync_id | input | 8 | Identifier of that marker |

## Verification
The queues are driven with short bursts, overfill past the depth, and drain through empty. These patterns separate correct ordering and room arithmetic from off-by-one full and empty decisions. Peek and pop reads are interleaved on the receive queue, which shows whether peeking is side-effect free. Interrupt traffic writes clear masks while a condition is still active and after it has gone, so a design where clearing wins over setting stands apart from one where setting wins. Asserting core reset with data in every queue and a stored marker shows that flushing covers all state it must cover.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam logic [7:0] OFS_VERSION  = 8'h00;
  localparam logic [7:0] OFS_CORE_RST = 8'h40;
  localparam logic [7:0] OFS_IRQ_EN   = 8'h80;
  localparam logic [7:0] OFS_IRQ_PEND = 8'h84;
  localparam logic [7:0] OFS_IRQ_SRC  = 8'h88;
  localparam logic [7:0] OFS_SYNC     = 8'hC0;
  localparam logic [7:0] OFS_CMD_ROOM = 8'hD0;
  localparam logic [7:0] OFS_TX_ROOM  = 8'hD4;
  localparam logic [7:0] OFS_RX_LVL   = 8'hD8;
  localparam logic [7:0] OFS_CMD_PUSH = 8'hE0;
  localparam logic [7:0] OFS_TX_PUSH  = 8'hE4;
  localparam logic [7:0] OFS_RX_POP   = 8'hE8;
  localparam logic [7:0] OFS_RX_PEEK  = 8'hEC;

  localparam int IRQ_N       = 4;
  localparam int IRQ_CMD_LOW = 0;
  localparam int IRQ_TX_LOW  = 1;
  localparam int IRQ_RX_HIGH = 2;
  localparam int IRQ_SYNC    = 3;

  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/srf_fifo.sv
module srf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  logic [W-1:0]             wdata,
  input  logic                     pop,
  output logic [W-1:0]             head,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          push_ok, pop_ok;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;

  always_comb begin
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      lvl_d = '0;
    end else begin
      rd_d  = rd_q + AW'(pop_ok);
      wr_d  = wr_q + AW'(push_ok);
      lvl_d = lvl_q + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_q] <= wdata;
    end
  end

  assign head  = empty ? '0 : mem[rd_q];
  assign level = lvl_q;
endmodule

// File: rtl/srf_irq.sv
module srf_irq
  import srf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t src,
  input  logic     en_we,
  input  irq_vec_t en_wdata,
  input  irq_vec_t clr,
  output irq_vec_t en_q,
  output irq_vec_t pend_q,
  output logic     irq
);
  irq_vec_t en_d, pend_d;

  assign en_d = en_we ? en_wdata : en_q;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_pend
    assign pend_d[i] = (pend_q[i] & ~clr[i]) | src[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign irq = |(pend_q & en_q);
endmodule

// File: rtl/spi_seq_regfile.sv
module spi_seq_regfile
  import srf_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int TX_DEPTH  = 16,
  parameter int RX_DEPTH  = 16,
  parameter int CMD_W     = 16,
  parameter int DATA_W    = 8,
  parameter int SYNC_W    = 8,
  parameter int LOW_MARK  = 4,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0,
  parameter int VER_PATCH = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              eng_rst,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              cmd_pop,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              sync_valid,
  input  logic [SYNC_W-1:0] sync_id
);
  localparam int CMD_LW = $clog2(CMD_DEPTH) + 1;
  localparam int TX_LW  = $clog2(TX_DEPTH) + 1;
  localparam int RX_LW  = $clog2(RX_DEPTH) + 1;

  logic wr_hit, rd_hit;
  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;

  // core reset bit and marker identifier
  logic              core_rst_q, core_rst_d;
  logic [SYNC_W-1:0] sync_q, sync_d;

  assign core_rst_d = (wr_hit && bus_addr == OFS_CORE_RST) ? bus_wdata[0] : core_rst_q;

  always_comb begin
    if (core_rst_q)      sync_d = '0;
    else if (sync_valid) sync_d = sync_id;
    else                 sync_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_rst_q <= 1'b1;
      sync_q     <= '0;
    end else begin
      core_rst_q <= core_rst_d;
      sync_q     <= sync_d;
    end
  end

  assign eng_rst = core_rst_q;

  // queues
  logic [CMD_LW-1:0] cmd_lvl;
  logic [TX_LW-1:0]  tx_lvl;
  logic [RX_LW-1:0]  rx_lvl;
  logic              cmd_full, cmd_empty, tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic              cmd_push_req, tx_push_req, rx_pop_req;

  assign cmd_push_req = wr_hit && bus_addr == OFS_CMD_PUSH;
  assign tx_push_req  = wr_hit && bus_addr == OFS_TX_PUSH;
  assign rx_pop_req   = rd_hit && bus_addr == OFS_RX_POP;

  srf_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst_n(rst_n), .flush(core_rst_q),
    .push(cmd_push_req), .wdata(bus_wdata[CMD_W-1:0]),
    .pop(cmd_pop), .head(cmd_data), .level(cmd_lvl),
    .full(cmd_full), .empty(cmd_empty)
  );

  srf_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(core_rst_q),
    .push(tx_push_req), .wdata(bus_wdata[DATA_W-1:0]),
    .pop(tx_pop), .head(tx_data), .level(tx_lvl),
    .full(tx_full), .empty(tx_empty)
  );

  srf_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(core_rst_q),
    .push(rx_push), .wdata(rx_data),
    .pop(rx_pop_req), .head(rx_head), .level(rx_lvl),
    .full(rx_full), .empty(rx_empty)
  );

  assign cmd_valid = ~cmd_empty;
  assign tx_valid  = ~tx_empty;

  // interrupt conditions
  irq_vec_t irq_src, irq_en, irq_pend, clr_mask;

  always_comb begin
    irq_src              = '0;
    irq_src[IRQ_CMD_LOW] = cmd_lvl <= CMD_LW'(LOW_MARK);
    irq_src[IRQ_TX_LOW]  = tx_lvl <= TX_LW'(LOW_MARK);
    irq_src[IRQ_RX_HIGH] = rx_lvl >= RX_LW'(RX_DEPTH - LOW_MARK);
    irq_src[IRQ_SYNC]    = sync_valid;
  end

  assign clr_mask = (wr_hit && bus_addr == OFS_IRQ_PEND) ? bus_wdata[IRQ_N-1:0] : '0;

  srf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .src(irq_src),
    .en_we(wr_hit && bus_addr == OFS_IRQ_EN), .en_wdata(bus_wdata[IRQ_N-1:0]),
    .clr(clr_mask), .en_q(irq_en), .pend_q(irq_pend), .irq(irq)
  );

  // read data
  logic [CMD_LW-1:0] cmd_room;
  logic [TX_LW-1:0]  tx_room;
  assign cmd_room = CMD_LW'(CMD_DEPTH) - cmd_lvl;
  assign tx_room  = TX_LW'(TX_DEPTH) - tx_lvl;

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (bus_addr)
        OFS_VERSION:  bus_rdata = {8'd0, 8'(VER_MAJOR), 8'(VER_MINOR), 8'(VER_PATCH)};
        OFS_CORE_RST: bus_rdata = 32'(core_rst_q);
        OFS_IRQ_EN:   bus_rdata = 32'(irq_en);
        OFS_IRQ_PEND: bus_rdata = 32'(irq_pend);
        OFS_IRQ_SRC:  bus_rdata = 32'(irq_src);
        OFS_SYNC:     bus_rdata = 32'(sync_q);
        OFS_CMD_ROOM: bus_rdata = 32'(cmd_room);
        OFS_TX_ROOM:  bus_rdata = 32'(tx_room);
        OFS_RX_LVL:   bus_rdata = 32'(rx_lvl);
        OFS_RX_POP,
        OFS_RX_PEEK:  bus_rdata = 32'(rx_head);
        default:      bus_rdata = '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:CMD_W], cmd_full, tx_full, rx_full, rx_empty};
endmodule

// File: rtl/srf_checker.sv
module srf_checker
  import srf_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int TX_DEPTH  = 16,
  parameter int RX_DEPTH  = 16,
  parameter int SYNC_W    = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         eng_rst,
  input logic [$clog2(CMD_DEPTH):0]   cmd_lvl,
  input logic [$clog2(TX_DEPTH):0]    tx_lvl,
  input logic [$clog2(RX_DEPTH):0]    rx_lvl,
  input logic [SYNC_W-1:0]            sync_q,
  input irq_vec_t                     src,
  input irq_vec_t                     pend,
  input irq_vec_t                     en,
  input irq_vec_t                     clr_mask,
  input logic                         irq,
  input logic                         rx_rd,
  input logic                         rx_push,
  input logic [31:0]                  bus_rdata
);
  // R3
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rst && $past(eng_rst)) |-> (cmd_lvl == '0 && tx_lvl == '0 && rx_lvl == '0 && sync_q == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cmd_lvl) <= CMD_DEPTH) && (int'(tx_lvl) <= TX_DEPTH) && (int'(rx_lvl) <= RX_DEPTH));

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(pend) & ~$past(clr_mask) & ~pend) == '0));

  // R10
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(src) & ~pend) == '0));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_lvl == '0) |-> (bus_rdata == '0));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_lvl == '0 && !rx_push) |=> (rx_lvl == '0));
endmodule

bind spi_seq_regfile srf_checker #(
  .CMD_DEPTH(CMD_DEPTH), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .SYNC_W(SYNC_W)
) u_srf_chk (
  .clk(clk), .rst_n(rst_n), .eng_rst(eng_rst),
  .cmd_lvl(cmd_lvl), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .sync_q(sync_q),
  .src(irq_src), .pend(irq_pend), .en(irq_en), .clr_mask(clr_mask),
  .irq(irq), .rx_rd(rx_pop_req), .rx_push(rx_push), .bus_rdata(bus_rdata)
);

// File: tb/test_spi_seq_regfile.sv
module test_spi_seq_regfile;
  localparam int D = 16;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, eng_rst, cmd_valid, tx_valid;
  logic [15:0] cmd_data;
  logic [7:0]  tx_data, rx_data, sync_id;
  logic        cmd_pop, tx_pop, rx_push, sync_valid;

  spi_seq_regfile i_spi_seq_regfile (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .eng_rst(eng_rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_pop(cmd_pop), .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .sync_valid(sync_valid), .sync_id(sync_id)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_cmd[$];
  logic [7:0]  m_tx[$];
  logic [7:0]  m_rx[$];
  logic        m_rst;
  logic [3:0]  m_en, m_pend, s_now, clr;
  logic [7:0]  m_sync;
  int          cl, tl, rl;
  logic        old_rst;

  function automatic logic [3:0] model_src();
    return {sync_valid, m_rx.size() >= D - 4, m_tx.size() <= 4, m_cmd.size() <= 4};
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return 32'h0001_0061;
      8'h40: return 32'(m_rst);
      8'h80: return 32'(m_en);
      8'h84: return 32'(m_pend);
      8'h88: return 32'(model_src());
      8'hC0: return 32'(m_sync);
      8'hD0: return 32'(D - m_cmd.size());
      8'hD4: return 32'(D - m_tx.size());
      8'hD8: return 32'(m_rx.size());
      8'hE8, 8'hEC: return (m_rx.size() > 0) ? 32'(m_rx[0]) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst = 1'b1; m_en = '0; m_pend = '0; m_sync = '0;
      m_cmd.delete(); m_tx.delete(); m_rx.delete();
    end else begin
      cl = m_cmd.size(); tl = m_tx.size(); rl = m_rx.size();
      s_now = model_src();
      old_rst = m_rst;
      clr = (bus_sel && bus_wr && bus_addr == 8'h84) ? bus_wdata[3:0] : 4'h0;
      m_pend = (m_pend & ~clr) | s_now;
      if (bus_sel && bus_wr && bus_addr == 8'h80) m_en = bus_wdata[3:0];
      if (bus_sel && bus_wr && bus_addr == 8'h40) m_rst = bus_wdata[0];
      if (old_rst) begin
        m_cmd.delete(); m_tx.delete(); m_rx.delete(); m_sync = '0;
      end else begin
        if (cmd_pop && cl > 0) void'(m_cmd.pop_front());
        if (bus_sel && bus_wr && bus_addr == 8'hE0 && cl < D) m_cmd.push_back(bus_wdata[15:0]);
        if (tx_pop && tl > 0) void'(m_tx.pop_front());
        if (bus_sel && bus_wr && bus_addr == 8'hE4 && tl < D) m_tx.push_back(bus_wdata[7:0]);
        if (bus_sel && !bus_wr && bus_addr == 8'hE8 && rl > 0) void'(m_rx.pop_front());
        if (rx_push && rl < D) m_rx.push_back(rx_data);
        if (sync_valid) m_sync = sync_id;
      end
    end
  end

  // every-clock comparison of the engine-facing outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 irq", 32'(irq), 32'(|(m_pend & m_en)));
      chk("R2 eng_rst", 32'(eng_rst), 32'(m_rst));
      chk("R4 cmd_valid", 32'(cmd_valid), 32'(m_cmd.size() > 0));
      chk("R4 cmd_data", 32'(cmd_data), (m_cmd.size() > 0) ? 32'(m_cmd[0]) : 32'd0);
      chk("R5 tx_valid", 32'(tx_valid), 32'(m_tx.size() > 0));
      chk("R5 tx_data", 32'(tx_data), (m_tx.size() > 0) ? 32'(m_tx[0]) : 32'd0);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    chk(req, bus_rdata, model_read(a));
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic eng(logic cp, logic tp, logic rp, logic [7:0] rd_byte, logic sv, logic [7:0] sid);
    @(negedge clk);
    cmd_pop = cp; tx_pop = tp; rx_push = rp; rx_data = rd_byte; sync_valid = sv; sync_id = sid;
    @(negedge clk);
    cmd_pop = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; sync_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cmd_pop = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_data = '0;
    sync_valid = 1'b0; sync_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd("R1 version", 8'h00);
    rd("R2 reset bit after rst_n", 8'h40);
    rd("R11 enable after rst_n", 8'h80);
    wr(8'hE0, 32'h1234);
    rd("R3 cmd push ignored in reset", 8'hD0);
    eng(1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 8'h00);
    rd("R3 rx push ignored in reset", 8'hD8);
    wr(8'h40, 32'h0);
    rd("R2 reset bit cleared", 8'h40);

    wr(8'hE0, 32'hFFFF_A001);
    wr(8'hE0, 32'hA002);
    wr(8'hE0, 32'hA003);
    rd("R4 cmd room", 8'hD0);
    eng(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    rd("R4 cmd room after pop", 8'hD0);
    rd("R9 source low marks", 8'h88);

    for (int i = 0; i < D + 1; i++) wr(8'hE4, 32'h10 + i);
    rd("R7 tx room full", 8'hD4);
    eng(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    eng(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    rd("R5 tx room", 8'hD4);

    eng(1'b0, 1'b0, 1'b1, 8'hC1, 1'b0, 8'h00);
    eng(1'b0, 1'b0, 1'b1, 8'hC2, 1'b0, 8'h00);
    rd("R6 rx level", 8'hD8);
    rd("R6 rx peek", 8'hEC);
    rd("R6 rx peek again", 8'hEC);
    rd("R6 rx pop", 8'hE8);
    rd("R6 rx pop", 8'hE8);
    rd("R8 rx pop empty", 8'hE8);
    rd("R8 rx peek empty", 8'hEC);
    rd("R8 rx level after empty read", 8'hD8);

    for (int i = 0; i < D + 1; i++) eng(1'b0, 1'b0, 1'b1, 8'h40 + 8'(i), 1'b0, 8'h00);
    rd("R7 rx level full", 8'hD8);
    rd("R9 source rx high", 8'h88);
    rd("R10 pending", 8'h84);
    wr(8'h80, 32'hF);
    rd("R11 enable", 8'h80);
    wr(8'h84, 32'hF);
    rd("R10 pending after clear, active sources", 8'h84);
    for (int i = 0; i < D; i++) rd("R6 rx drain", 8'hE8);
    rd("R7 rx oldest kept", 8'hEC);
    wr(8'h84, 32'h4);
    rd("R10 pending rx bit cleared", 8'h84);
    wr(8'h84, 32'h0);
    rd("R10 zero write keeps bits", 8'h84);
    wr(8'h80, 32'h0);

    eng(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h5A);
    rd("R12 sync id", 8'hC0);
    rd("R10 sync pending", 8'h84);
    wr(8'h80, 32'h8);
    rd("R11 enable sync only", 8'h80);
    wr(8'h84, 32'h8);
    rd("R10 sync cleared", 8'h84);

    wr(8'hE0, 32'hB001);
    eng(1'b0, 1'b0, 1'b1, 8'hD1, 1'b0, 8'h00);
    wr(8'h40, 32'h1);
    rd("R3 cmd flushed", 8'hD0);
    rd("R3 tx flushed", 8'hD4);
    rd("R3 rx flushed", 8'hD8);
    rd("R3 sync id zero", 8'hC0);
    rd("R2 reset bit set", 8'h40);
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end
endmodule